// File: doc/BRIEF.md
# Multi-cycle integer multiply and divide unit

This block performs integer multiplication and division, signed or unsigned, at two operand sizes. In byte mode the source is 8 bits wide and the destination is 16 bits wide. In word mode the source is 16 bits wide and the destination is 32 bits wide. A one-cycle `start` pulse captures the operands and the operation. The unit then works for a fixed number of cycles and raises `done` for exactly one cycle. In that cycle the packed destination value and the N and Z flags are valid, and they stay valid until the next completion.

A multiply takes only the low half of the destination as its multiplicand. The full-width product replaces the destination field. A divide treats the whole destination field as the dividend. It uses a restoring shift-subtract loop on magnitudes, then applies signs at the end. It writes the quotient into the low half of the destination field and the remainder into the high half. In byte mode, bits 31:16 of the destination pass through unchanged.

Top module: `muldiv_unit`

## Requirements
- R1: Byte multiply forms the 16-bit product of `dst_in[7:0]` and `src_in[7:0]` in `result[15:0]`, and `result[31:16]` equals `dst_in[31:16]`.
- R2: Word multiply forms the 32-bit product of `dst_in[15:0]` and `src_in` in `result`. `dst_in[31:16]` has no effect on the product.
- R3: With `is_signed`=1 both multiply operands are sign-extended. With `is_signed`=0 they are zero-extended.
- R4: After a multiply, `flag_n` equals the top bit of the product (bit 15 for byte, bit 31 for word). `flag_z` is 1 exactly when the whole product is zero.
- R5: Byte divide divides `dst_in[15:0]` by `src_in[7:0]`. The quotient goes to `result[7:0]`, the remainder to `result[15:8]`, and `result[31:16]` equals `dst_in[31:16]`.
- R6: Word divide divides `dst_in` by `src_in`. The quotient goes to `result[15:0]` and the remainder to `result[31:16]`.
- R7: Signed divide truncates toward zero, and the remainder takes the sign of the dividend. For any divide, `flag_n` is the top bit of the quotient field and `flag_z` is 1 when the quotient field is zero.
- R8: A divide by a zero divisor returns `result` equal to `dst_in`, with `flag_z`=1 and `flag_n`=0.
- R9: `done` is a single-cycle pulse. Counted from the clock edge that accepts `start`, `done` is high after edge 2 for a multiply, after edge 17 for a byte divide and after edge 33 for a word divide.
- R10: A `start` raised while an operation is in flight is ignored. That operation completes on its own schedule with its own operands.
- R11: After reset, `result` is zero, both flags are 0 and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation; honoured only when idle |
| op_div | input | 1 | 1 selects divide, 0 selects multiply |
| is_signed | input | 1 | 1 selects signed operands |
| is_word | input | 1 | 1 selects word size, 0 selects byte size |
| dst_in | input | 32 | Destination register value (dividend or multiplicand) |
| src_in | input | 16 | Source register value (divisor or multiplier) |
| result | output | 32 | Packed destination result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| done | output | 1 | One-cycle completion pulse |

## Verification
The in-line properties take for granted that the operands held in the unit do not change until the operation completes. They check this themselves and rely on it for the quotient-times-divisor-plus-remainder identity. That identity is checked only for unsigned word divides whose quotient fits in 16 bits. The bench keeps the stimulus within these assumptions in three ways. It changes the operand pins only on falling edges. It pulses `start` for a single cycle. It applies a second `start` mid-operation only to show that the unit ignores it.

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
  parameter int SRC_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               op_div,
  input  logic               is_signed,
  input  logic               is_word,
  input  logic [2*SRC_W-1:0] dst_in,
  input  logic [SRC_W-1:0]   src_in,
  output logic [2*SRC_W-1:0] result,
  output logic               flag_n,
  output logic               flag_z,
  output logic               done
);
  localparam int DST_W = 2 * SRC_W;
  localparam int HALF  = SRC_W / 2;
  localparam int CW    = $clog2(DST_W + 1);

  logic             busy, div_q, sgn_q, word_q, qneg_q, rneg_q;
  logic [CW-1:0]    cnt;
  logic [DST_W-1:0] dst_q, shq;
  logic [SRC_W-1:0] src_q, dsor;
  logic [SRC_W:0]   part;

  logic [DST_W-1:0] dend_x, dend_mag;
  logic [SRC_W-1:0] dsor_x, dsor_mag;
  logic             dend_neg, dsor_neg;

  always_comb begin
    dend_x   = is_word ? dst_in : {{SRC_W{is_signed & dst_in[SRC_W-1]}}, dst_in[SRC_W-1:0]};
    dsor_x   = is_word ? src_in : {{HALF{is_signed & src_in[HALF-1]}}, src_in[HALF-1:0]};
    dend_neg = is_signed & dend_x[DST_W-1];
    dsor_neg = is_signed & dsor_x[SRC_W-1];
    dend_mag = dend_neg ? -dend_x : dend_x;
    dsor_mag = dsor_neg ? -dsor_x : dsor_x;
  end

  logic [SRC_W:0] part_sh;
  logic           fits;
  assign part_sh = {part[SRC_W-1:0], shq[DST_W-1]};
  assign fits    = part_sh >= {1'b0, dsor};

  logic [DST_W-1:0] quo, rem, mul_a, mul_b, prod;
  assign quo   = qneg_q ? -shq : shq;
  assign rem   = rneg_q ? -DST_W'(part) : DST_W'(part);
  assign mul_a = word_q ? {{SRC_W{sgn_q & dst_q[SRC_W-1]}}, dst_q[SRC_W-1:0]}
                        : {{(DST_W-HALF){sgn_q & dst_q[HALF-1]}}, dst_q[HALF-1:0]};
  assign mul_b = word_q ? {{SRC_W{sgn_q & src_q[SRC_W-1]}}, src_q}
                        : {{(DST_W-HALF){sgn_q & src_q[HALF-1]}}, src_q[HALF-1:0]};
  assign prod  = mul_a * mul_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; cnt <= '0; done <= 1'b0;
      div_q <= 1'b0; sgn_q <= 1'b0; word_q <= 1'b0; qneg_q <= 1'b0; rneg_q <= 1'b0;
      dst_q <= '0; src_q <= '0; shq <= '0; dsor <= '0; part <= '0;
      result <= '0; flag_n <= 1'b0; flag_z <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          cnt    <= !op_div ? CW'(1) : (is_word ? CW'(DST_W) : CW'(SRC_W));
          div_q  <= op_div;
          sgn_q  <= is_signed;
          word_q <= is_word;
          dst_q  <= dst_in;
          src_q  <= src_in;
          qneg_q <= dend_neg ^ dsor_neg;
          rneg_q <= dend_neg;
          dsor   <= dsor_mag;
          part   <= '0;
          shq    <= is_word ? dend_mag : {dend_mag[SRC_W-1:0], {SRC_W{1'b0}}};
        end
      end else if (cnt != '0) begin
        cnt <= cnt - CW'(1);
        if (div_q) begin
          part <= fits ? part_sh - {1'b0, dsor} : part_sh;
          shq  <= {shq[DST_W-2:0], fits};
        end
      end else begin
        busy <= 1'b0;
        done <= 1'b1;
        if (div_q && dsor == '0) begin
          result <= dst_q; flag_n <= 1'b0; flag_z <= 1'b1;
        end else if (div_q && word_q) begin
          result <= {rem[SRC_W-1:0], quo[SRC_W-1:0]};
          flag_n <= quo[SRC_W-1];
          flag_z <= quo[SRC_W-1:0] == '0;
        end else if (div_q) begin
          result <= {dst_q[DST_W-1:SRC_W], rem[HALF-1:0], quo[HALF-1:0]};
          flag_n <= quo[HALF-1];
          flag_z <= quo[HALF-1:0] == '0;
        end else if (word_q) begin
          result <= prod;
          flag_n <= prod[DST_W-1];
          flag_z <= prod == '0;
        end else begin
          result <= {dst_q[DST_W-1:SRC_W], prod[SRC_W-1:0]};
          flag_n <= prod[SRC_W-1];
          flag_z <= prod[SRC_W-1:0] == '0;
        end
      end
    end
  end

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_start_taken_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_ops_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(dst_q) && $stable(src_q) && $stable(div_q)));

  p_mul_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_q && word_q) |-> (flag_z == (result == '0)));

  p_rem_small_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_q && !sgn_q && word_q && src_q != '0)
      |-> (result[DST_W-1:SRC_W] < src_q));

  p_div_ident_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_q && !sgn_q && word_q && src_q != '0 && dst_q[DST_W-1:SRC_W] < src_q)
      |-> (DST_W'(result[SRC_W-1:0]) * DST_W'(src_q) + DST_W'(result[DST_W-1:SRC_W]) == dst_q));
endmodule

// File: tb/muldiv_unit_tb_top.sv
module muldiv_unit_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, op_div = 1'b0, is_signed = 1'b0, is_word = 1'b0;
  logic [31:0] dst_in = '0, result;
  logic [15:0] src_in = '0;
  logic flag_n, flag_z, done;
  int checks = 0, fails = 0, lat = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  muldiv_unit dut_i (.clk, .rst_n, .start, .op_div, .is_signed, .is_word,
                     .dst_in, .src_in, .result, .flag_n, .flag_z, .done);

  localparam string TAG [8] = '{"R1", "R2", "R3", "R5", "R6", "R7", "R8", "R3"};
  localparam int NV = 18;
  // {tag index, div, signed, word, dst, src, expected result, N, Z}
  localparam logic [88:0] VEC [NV] = '{
    {4'd0, 1'b0,1'b0,1'b0, 32'h5555_3412, 16'hEE34, 32'h5555_03A8, 1'b0,1'b0},
    {4'd2, 1'b0,1'b1,1'b0, 32'h0000_12FE, 16'h0005, 32'h0000_FFF6, 1'b1,1'b0},
    {4'd0, 1'b0,1'b0,1'b0, 32'h0000_12FE, 16'h0005, 32'h0000_04F6, 1'b0,1'b0},
    {4'd2, 1'b0,1'b1,1'b0, 32'h0000_0080, 16'h0080, 32'h0000_4000, 1'b0,1'b0},
    {4'd7, 1'b0,1'b1,1'b1, 32'h1234_FFFF, 16'h8000, 32'h0000_8000, 1'b0,1'b0},
    {4'd1, 1'b0,1'b0,1'b1, 32'h1234_FFFF, 16'h8000, 32'h7FFF_8000, 1'b0,1'b0},
    {4'd1, 1'b0,1'b0,1'b1, 32'h0000_FFFF, 16'hFFFF, 32'hFFFE_0001, 1'b1,1'b0},
    {4'd1, 1'b0,1'b1,1'b1, 32'hFFFF_0000, 16'h1234, 32'h0000_0000, 1'b0,1'b1},
    {4'd3, 1'b1,1'b0,1'b0, 32'hAAAA_0064, 16'h0007, 32'hAAAA_020E, 1'b0,1'b0},
    {4'd5, 1'b1,1'b1,1'b0, 32'h0000_FF9C, 16'h0007, 32'h0000_FEF2, 1'b1,1'b0},
    {4'd5, 1'b1,1'b1,1'b0, 32'h0000_0064, 16'h00F9, 32'h0000_02F2, 1'b1,1'b0},
    {4'd5, 1'b1,1'b1,1'b0, 32'h0000_FF9C, 16'h00F9, 32'h0000_FE0E, 1'b0,1'b0},
    {4'd3, 1'b1,1'b0,1'b0, 32'h0000_0005, 16'h0009, 32'h0000_0500, 1'b0,1'b1},
    {4'd4, 1'b1,1'b0,1'b1, 32'h0001_0000, 16'h0003, 32'h0001_5555, 1'b0,1'b0},
    {4'd5, 1'b1,1'b1,1'b1, 32'hFFFF_FFF9, 16'h0002, 32'hFFFF_FFFD, 1'b1,1'b0},
    {4'd4, 1'b1,1'b0,1'b1, 32'h0000_9000, 16'h0001, 32'h0000_9000, 1'b1,1'b0},
    {4'd6, 1'b1,1'b0,1'b0, 32'h1234_5678, 16'hFF00, 32'h1234_5678, 1'b0,1'b1},
    {4'd6, 1'b1,1'b1,1'b1, 32'hCAFE_BABE, 16'h0000, 32'hCAFE_BABE, 1'b0,1'b1}
  };

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic launch(input logic d, input logic s, input logic w, input logic [31:0] a, input logic [15:0] b);
    @(negedge clk);
    op_div = d; is_signed = s; is_word = w; dst_in = a; src_in = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
  endtask

  task automatic wait_done();
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11", "result in reset", result, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", "flags/done after reset", {29'h0, flag_n, flag_z, done}, 32'h0);
    check("R11", "result after reset", result, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [88:0] v;
      int exp_lat;
      v = VEC[i];
      exp_lat = !v[84] ? 2 : (v[82] ? 33 : 17);
      launch(v[84], v[83], v[82], v[81:50], v[49:34]);
      wait_done();
      check("R9", $sformatf("latency vec %0d", i), lat, exp_lat);
      check(TAG[v[88:85]], $sformatf("result vec %0d", i), result, v[33:2]);
      check(v[84] ? TAG[v[88:85]] : "R4", $sformatf("N,Z vec %0d", i), {30'h0, flag_n, flag_z}, {30'h0, v[1:0]});
      @(negedge clk);
      check("R9", $sformatf("done width vec %0d", i), {31'h0, done}, 32'h0);
    end

    // R10: second start mid-operation is ignored
    launch(1'b1, 1'b0, 1'b1, 32'h0001_0000, 16'h0003);
    repeat (3) begin @(negedge clk); lat++; end
    op_div = 1'b0; is_signed = 1'b1; is_word = 1'b0; dst_in = 32'h0000_0077; src_in = 16'h0002; start = 1'b1;
    @(negedge clk); lat++;
    start = 1'b0;
    wait_done();
    check("R10", "latency with stray start", lat, 33);
    check("R10", "result with stray start", result, 32'h0001_5555);
    @(negedge clk);
    check("R10", "no second completion", {31'h0, done}, 32'h0);
    repeat (4) @(negedge clk);
    check("R10", "result held", result, 32'h0001_5555);

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule